// File: doc/BRIEF.md
# Iterative AES-128 Round Engine

This block encrypts or decrypts one 128-bit block with a 128-bit key, one cipher round per clock. A one-cycle `start_i` samples the block, the key and the direction bit. The engine then applies the initial key addition and ten rounds to its state register. On every round it steps its own key register forward, or backward, through the key schedule. No table of round keys is stored.

For encryption the key input is the ordinary cipher key. When encryption ends, the key register holds the tenth (final) round key. For decryption the key input must be that final round key. The engine rebuilds each earlier round key on the fly, so when decryption ends the key register holds the original cipher key again. To obtain a decryption key, encrypt any block with the cipher key and read `key_o` afterwards.

The rounds finish early in the run. Completion is paced by a counter so that `done_o` always comes a fixed `LATENCY` cycles (375 by default) after the start. This keeps the block's timing independent of how the rounds are scheduled.

Top module: `aes_iter_core`

## Requirements
- R1: After the asynchronous reset `rst_ni`, whether released while idle or applied in mid-operation, `busy_o` and `done_o` are 0 and `state_o` and `key_o` are all zero. An operation cut off by reset never raises `done_o`.
- R2: With `decrypt_i` = 0, `state_o` ends as the AES-128 ciphertext of `state_i` under `key_i`. Byte n of a block or key sits in bits [127-8n -: 8], the standard column-major byte order. An example is key 000102..0f with plaintext 00112233..ff, which gives 69c4e0d8..c55a.
- R3: After an encryption, `key_o` holds the final (round-10) round key of `key_i`. For example, key 000102..0f leaves 13111d7fe3944a17f307a78b4d2b30c5.
- R4: With `decrypt_i` = 1 and `key_i` set to a final round key, `state_o` ends as the AES-128 plaintext of `state_i`.
- R5: After a decryption, `key_o` holds the original cipher key that produced the given final round key.
- R6: `done_o` is high for exactly one cycle. It rises `LATENCY` (375) clock edges after the edge that sampled an accepted `start_i`, and `state_o`/`key_o` hold the results from that cycle on.
- R7: `busy_o` is high from the edge that accepts `start_i` until the edge that raises `done_o`, and falls together with `done_o` rising.
- R8: While `busy_o` is high, `start_i`, `decrypt_i`, `state_i` and `key_i` have no effect: neither the results nor the timing of `done_o` change.
- R9: Encrypting any block with a cipher key leaves in `key_o` the key that decrypts that cipher key's ciphertexts.
- R10: While idle and without `start_i`, `state_o` and `key_o` hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start request, accepted only when idle |
| decrypt_i | input | 1 | 1 = decrypt, 0 = encrypt; sampled at start |
| state_i | input | 128 | Input block; sampled at start |
| key_i | input | 128 | Cipher key (encrypt) or final round key (decrypt); sampled at start |
| state_o | output | 128 | State register: result after done |
| key_o | output | 128 | Key register: opposite end of the schedule after done |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | One-cycle completion pulse |

## Verification
The state and key results and the fall of `busy_o` are all due on the same edge, exactly 375 edges after the edge that samples the start, and `done_o` drops one edge later. The bench drives inputs on falling edges and samples 1 ns after each rising edge. It counts rising edges from the one that sampled the start and requires `done_o` to appear at count 375, with `busy_o` high at every count before it. The results are compared in that same sample slot and again one edge later, where the pulse must be gone and the outputs unchanged.

// File: rtl/aes_pkg.sv
package aes_pkg;
  localparam int NR     = 10;
  localparam int RIDX_W = 4;

  function automatic logic [7:0] xtime(input logic [7:0] a);
    return {a[6:0], 1'b0} ^ (a[7] ? 8'h1b : 8'h00);
  endfunction

  function automatic logic [7:0] gf_mul(input logic [7:0] a, input logic [7:0] b);
    logic [7:0] p, x;
    p = 8'h00;
    x = a;
    for (int i = 0; i < 8; i++) begin
      if (b[i]) p = p ^ x;
      x = xtime(x);
    end
    return p;
  endfunction

  // a^254 is the multiplicative inverse (0 maps to 0)
  function automatic logic [7:0] gf_inv(input logic [7:0] a);
    logic [7:0] r, p;
    r = 8'h01;
    p = a;
    for (int i = 1; i < 8; i++) begin
      p = gf_mul(p, p);
      r = gf_mul(r, p);
    end
    return r;
  endfunction

  function automatic logic [7:0] rotl8(input logic [7:0] v, input int k);
    return (v << k) | (v >> (8 - k));
  endfunction

  function automatic logic [7:0] sbox(input logic [7:0] a);
    logic [7:0] b;
    b = gf_inv(a);
    return b ^ rotl8(b, 1) ^ rotl8(b, 2) ^ rotl8(b, 3) ^ rotl8(b, 4) ^ 8'h63;
  endfunction

  function automatic logic [7:0] inv_sbox(input logic [7:0] a);
    logic [7:0] y;
    y = a ^ 8'h63;
    return gf_inv(rotl8(y, 1) ^ rotl8(y, 3) ^ rotl8(y, 6));
  endfunction

  function automatic logic [7:0] rcon(input logic [RIDX_W-1:0] idx);
    logic [7:0] rc;
    rc = 8'h01;
    for (int j = 2; j <= NR; j++)
      if (RIDX_W'(j) <= idx) rc = xtime(rc);
    return rc;
  endfunction

  function automatic logic [31:0] sub_rot(input logic [31:0] w);
    logic [31:0] r;
    r = {w[23:0], w[31:24]};
    return {sbox(r[31:24]), sbox(r[23:16]), sbox(r[15:8]), sbox(r[7:0])};
  endfunction

  function automatic logic [31:0] mix_col(input logic [31:0] c);
    logic [7:0] a0, a1, a2, a3;
    {a0, a1, a2, a3} = c;
    return {xtime(a0) ^ xtime(a1) ^ a1 ^ a2 ^ a3,
            a0 ^ xtime(a1) ^ xtime(a2) ^ a2 ^ a3,
            a0 ^ a1 ^ xtime(a2) ^ xtime(a3) ^ a3,
            xtime(a0) ^ a0 ^ a1 ^ a2 ^ xtime(a3)};
  endfunction

  function automatic logic [31:0] inv_mix_col(input logic [31:0] c);
    logic [7:0] a0, a1, a2, a3;
    {a0, a1, a2, a3} = c;
    return {gf_mul(a0, 8'h0e) ^ gf_mul(a1, 8'h0b) ^ gf_mul(a2, 8'h0d) ^ gf_mul(a3, 8'h09),
            gf_mul(a0, 8'h09) ^ gf_mul(a1, 8'h0e) ^ gf_mul(a2, 8'h0b) ^ gf_mul(a3, 8'h0d),
            gf_mul(a0, 8'h0d) ^ gf_mul(a1, 8'h09) ^ gf_mul(a2, 8'h0e) ^ gf_mul(a3, 8'h0b),
            gf_mul(a0, 8'h0b) ^ gf_mul(a1, 8'h0d) ^ gf_mul(a2, 8'h09) ^ gf_mul(a3, 8'h0e)};
  endfunction
endpackage

// File: rtl/aes_key_step.sv
module aes_key_step #(
  parameter bit BACKWARD = 1'b0
) (
  input  logic [127:0] key_i,
  input  logic [7:0]   rcon_i,
  output logic [127:0] key_o
);
  logic [31:0] w0, w1, w2, w3;
  assign {w0, w1, w2, w3} = key_i;

  generate
    if (!BACKWARD) begin : g_fwd
      logic [31:0] n0, n1, n2, n3;
      assign n0 = w0 ^ aes_pkg::sub_rot(w3) ^ {rcon_i, 24'h0};
      assign n1 = w1 ^ n0;
      assign n2 = w2 ^ n1;
      assign n3 = w3 ^ n2;
      assign key_o = {n0, n1, n2, n3};
    end else begin : g_bwd
      // rebuild the earlier key: last word first, then word 0 from it
      logic [31:0] p0, p1, p2, p3;
      assign p3 = w3 ^ w2;
      assign p2 = w2 ^ w1;
      assign p1 = w1 ^ w0;
      assign p0 = w0 ^ aes_pkg::sub_rot(p3) ^ {rcon_i, 24'h0};
      assign key_o = {p0, p1, p2, p3};
    end
  endgenerate
endmodule

// File: rtl/aes_round_enc.sv
module aes_round_enc (
  input  logic [127:0] state_i,
  input  logic [127:0] rkey_i,
  input  logic         last_i,
  output logic [127:0] state_o
);
  logic [127:0] shifted, mixed;

  for (genvar c = 0; c < 4; c++) begin : g_col
    for (genvar r = 0; r < 4; r++) begin : g_row
      assign shifted[127-8*(r+4*c) -: 8] =
        aes_pkg::sbox(state_i[127-8*(r+4*((c+r)%4)) -: 8]);
    end
    assign mixed[127-32*c -: 32] = aes_pkg::mix_col(shifted[127-32*c -: 32]);
  end

  assign state_o = (last_i ? shifted : mixed) ^ rkey_i;
endmodule

// File: rtl/aes_round_dec.sv
module aes_round_dec (
  input  logic [127:0] state_i,
  input  logic [127:0] rkey_i,
  input  logic         last_i,
  output logic [127:0] state_o
);
  logic [127:0] subbed, keyed, unmixed;

  for (genvar c = 0; c < 4; c++) begin : g_col
    for (genvar r = 0; r < 4; r++) begin : g_row
      assign subbed[127-8*(r+4*c) -: 8] =
        aes_pkg::inv_sbox(state_i[127-8*(r+4*((c-r+4)%4)) -: 8]);
    end
    assign unmixed[127-32*c -: 32] = aes_pkg::inv_mix_col(keyed[127-32*c -: 32]);
  end

  assign keyed   = subbed ^ rkey_i;
  assign state_o = last_i ? keyed : unmixed;
endmodule

// File: rtl/aes_seq.sv
module aes_seq #(
  parameter int unsigned LATENCY = 375
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        start_i,
  output logic                        accept_o,
  output logic                        round_en_o,
  output logic                        last_o,
  output logic [aes_pkg::RIDX_W-1:0]  round_idx_o,
  output logic                        busy_o,
  output logic                        done_o
);
  localparam int CNT_W = $clog2(LATENCY + 1);

  logic [CNT_W-1:0] cnt_q;
  logic             busy_q, done_q;

  assign accept_o    = start_i && !busy_q;
  assign round_en_o  = busy_q && (cnt_q != '0) && (cnt_q <= CNT_W'(aes_pkg::NR));
  assign last_o      = cnt_q == CNT_W'(aes_pkg::NR);
  assign round_idx_o = cnt_q[aes_pkg::RIDX_W-1:0];
  assign busy_o      = busy_q;
  assign done_o      = done_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      busy_q <= 1'b0;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (accept_o) begin
        busy_q <= 1'b1;
        cnt_q  <= CNT_W'(1);
      end else if (busy_q) begin
        if (cnt_q == CNT_W'(LATENCY)) begin
          busy_q <= 1'b0;
          done_q <= 1'b1;
          cnt_q  <= '0;
        end else begin
          cnt_q <= cnt_q + CNT_W'(1);
        end
      end
    end
  end
endmodule

// File: rtl/aes_iter_core.sv
module aes_iter_core #(
  parameter int unsigned LATENCY = 375
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         start_i,
  input  logic         decrypt_i,
  input  logic [127:0] state_i,
  input  logic [127:0] key_i,
  output logic [127:0] state_o,
  output logic [127:0] key_o,
  output logic         busy_o,
  output logic         done_o
);
  localparam int RW = aes_pkg::RIDX_W;

  logic          accept, round_en, last;
  logic [RW-1:0] round_idx;
  logic          dec_q;
  logic [127:0]  state_q, key_q;
  logic [127:0]  key_fwd, key_bwd, enc_nxt, dec_nxt;
  logic [7:0]    rcon_fwd, rcon_bwd;

  aes_seq #(.LATENCY(LATENCY)) u_seq (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .start_i    (start_i),
    .accept_o   (accept),
    .round_en_o (round_en),
    .last_o     (last),
    .round_idx_o(round_idx),
    .busy_o     (busy_o),
    .done_o     (done_o)
  );

  // backward steps walk the constants from the top of the list down
  assign rcon_fwd = aes_pkg::rcon(round_idx);
  assign rcon_bwd = aes_pkg::rcon(RW'(aes_pkg::NR + 1) - round_idx);

  aes_key_step #(.BACKWARD(1'b0)) u_key_fwd (.key_i(key_q), .rcon_i(rcon_fwd), .key_o(key_fwd));
  aes_key_step #(.BACKWARD(1'b1)) u_key_bwd (.key_i(key_q), .rcon_i(rcon_bwd), .key_o(key_bwd));

  aes_round_enc u_enc (.state_i(state_q), .rkey_i(key_fwd), .last_i(last), .state_o(enc_nxt));
  aes_round_dec u_dec (.state_i(state_q), .rkey_i(key_bwd), .last_i(last), .state_o(dec_nxt));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= '0;
      key_q   <= '0;
      dec_q   <= 1'b0;
    end else if (accept) begin
      state_q <= state_i ^ key_i;
      key_q   <= key_i;
      dec_q   <= decrypt_i;
    end else if (round_en) begin
      state_q <= dec_q ? dec_nxt : enc_nxt;
      key_q   <= dec_q ? key_bwd : key_fwd;
    end
  end

  assign state_o = state_q;
  assign key_o   = key_q;
endmodule

// File: rtl/aes_iter_chk.sv
module aes_iter_chk #(
  parameter int unsigned LATENCY = 375
) (
  input logic         clk_i,
  input logic         rst_ni,
  input logic         start_i,
  input logic [127:0] state_o,
  input logic [127:0] key_o,
  input logic         busy_o,
  input logic         done_o
);
  localparam int CNT_W = $clog2(LATENCY + 1);

  logic             act_q;
  logic [CNT_W-1:0] ccnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act_q  <= 1'b0;
      ccnt_q <= '0;
    end else if (start_i && !busy_o) begin
      act_q  <= 1'b1;
      ccnt_q <= '0;
    end else if (act_q) begin
      ccnt_q <= ccnt_q + CNT_W'(1);
      if (done_o) act_q <= 1'b0;
    end
  end

  AST_DONE_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o); // R6
  AST_DONE_AT_LATENCY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (act_q && ccnt_q == CNT_W'(LATENCY))); // R6
  AST_BUSY_ON_ACCEPT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !busy_o) |=> busy_o); // R7
  AST_BUSY_ENDS_WITH_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> done_o); // R7
  AST_NOT_BUSY_AND_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(busy_o && done_o)); // R7
  AST_IDLE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && !start_i) |=> ($stable(state_o) && $stable(key_o))); // R10
endmodule

bind aes_iter_core aes_iter_chk #(.LATENCY(LATENCY)) u_chk (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .start_i(start_i),
  .state_o(state_o),
  .key_o  (key_o),
  .busy_o (busy_o),
  .done_o (done_o)
);

// File: tb/tb_aes_iter_core.sv
module tb_aes_iter_core;
  localparam int LAT = 375;

  logic         clk = 1'b0;
  logic         rst_ni = 1'b0;
  logic         start = 1'b0;
  logic         decrypt = 1'b0;
  logic [127:0] st_in = '0;
  logic [127:0] key_in = '0;
  logic [127:0] state_o, key_o;
  logic         busy_o, done_o;

  int n_chk = 0;
  int n_err = 0;
  int busy_gaps;

  always #2 clk = ~clk;

  aes_iter_core #(.LATENCY(LAT)) dut (
    .clk_i(clk), .rst_ni(rst_ni), .start_i(start), .decrypt_i(decrypt),
    .state_i(st_in), .key_i(key_in), .state_o(state_o), .key_o(key_o),
    .busy_o(busy_o), .done_o(done_o)
  );

  localparam logic [127:0] K1  = 128'h000102030405060708090a0b0c0d0e0f;
  localparam logic [127:0] P1  = 128'h00112233445566778899aabbccddeeff;
  localparam logic [127:0] C1  = 128'h69c4e0d86a7b0430d8cdb78070b4c55a;
  localparam logic [127:0] L1  = 128'h13111d7fe3944a17f307a78b4d2b30c5;
  localparam logic [127:0] K2  = 128'h2b7e151628aed2a6abf7158809cf4f3c;
  localparam logic [127:0] P2  = 128'h3243f6a8885a308d313198a2e0370734;
  localparam logic [127:0] C2  = 128'h3925841d02dc09fbdc118597196a0b32;
  localparam logic [127:0] L2  = 128'hd014f9a8c9ee2589e13f0cc8b6630ca6;

  // {decrypt, key in, block in, expected block, expected key}
  localparam logic [512:0] VEC [0:3] = '{
    {1'b0, K1, P1, C1, L1},
    {1'b1, L1, C1, P1, K1},
    {1'b0, K2, P2, C2, L2},
    {1'b1, L2, C2, P2, K2}
  };

  task automatic chk128(input string req, input logic [127:0] act, input logic [127:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic chk_int(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Runs one operation; inj_at >= 0 drives junk and a start at that count.
  task automatic run_op(input logic dir, input logic [127:0] k, input logic [127:0] s,
                        input int inj_at, output int lat);
    @(negedge clk);
    decrypt = dir; key_in = k; st_in = s; start = 1'b1;
    @(posedge clk); #1;
    start = 1'b0;
    lat = 0;
    busy_gaps = 0;
    while (!done_o && lat < LAT + 25) begin
      if (lat == inj_at) begin
        start = 1'b1; decrypt = ~dir; key_in = ~k; st_in = ~s;
      end else begin
        start = 1'b0;
      end
      @(posedge clk); #1;
      lat++;
      if (!done_o && !busy_o) busy_gaps++;
    end
    start = 1'b0;
  endtask

  task automatic after_done(input string req, input logic [127:0] es, input logic [127:0] ek);
    chk_int({req, " busy low with done"}, int'(busy_o), 0);
    @(posedge clk); #1;
    chk_int({req, " R6 done pulse width"}, int'(done_o), 0);
    chk128({req, " R10 state held"}, state_o, es);
    chk128({req, " R10 key held"}, key_o, ek);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    int lat;
    logic [127:0] dk;

    repeat (3) @(posedge clk);
    #1;
    // R1: reset state
    chk_int("R1 busy after reset", int'(busy_o), 0);
    chk_int("R1 done after reset", int'(done_o), 0);
    chk128("R1 state after reset", state_o, '0);
    chk128("R1 key after reset", key_o, '0);
    @(negedge clk);
    rst_ni = 1'b1;
    @(posedge clk); #1;
    chk_int("R1 idle after release", int'(busy_o), 0);

    // table of reference vectors: R2 R3 R4 R5 R6 R7
    for (int i = 0; i < 4; i++) begin
      logic [512:0] v;
      v = VEC[i];
      run_op(v[512], v[511:384], v[383:256], -1, lat);
      chk_int(v[512] ? "R6 latency (decrypt)" : "R6 latency (encrypt)", lat, LAT);
      chk_int("R7 busy held until done", busy_gaps, 0);
      chk128(v[512] ? "R4 plaintext" : "R2 ciphertext", state_o, v[255:128]);
      chk128(v[512] ? "R5 original key" : "R3 final round key", key_o, v[127:0]);
      after_done(v[512] ? "dec" : "enc", v[255:128], v[127:0]);
    end

    // R8: start and new inputs while busy are ignored
    run_op(1'b0, K1, P1, 100, lat);
    chk_int("R8 latency with start while busy", lat, LAT);
    chk128("R8 ciphertext with start while busy", state_o, C1);
    chk128("R8 key with start while busy", key_o, L1);
    run_op(1'b1, L1, C1, 370, lat);
    chk_int("R8 late start while busy latency", lat, LAT);
    chk128("R8 late start while busy plaintext", state_o, P1);

    // R9: dummy block encrypt gives the decryption key
    run_op(1'b0, K2, '0, -1, lat);
    dk = key_o;
    chk128("R9 dummy zero block key", dk, L2);
    run_op(1'b0, K2, 128'hdeadbeef_01234567_89abcdef_55aa33cc, -1, lat);
    chk128("R9 dummy random block key", key_o, L2);
    run_op(1'b1, dk, C2, -1, lat);
    chk128("R9 decrypt with derived key", state_o, P2);

    // R10: idle outputs hold while inputs toggle without start
    @(negedge clk);
    st_in = ~st_in; key_in = ~key_in; decrypt = ~decrypt;
    repeat (20) @(posedge clk);
    #1;
    chk128("R10 idle state hold", state_o, P2);
    chk128("R10 idle key hold", key_o, K2);
    chk_int("R10 idle no done", int'(done_o), 0);

    // R1: reset in mid-operation
    @(negedge clk);
    decrypt = 1'b0; key_in = K1; st_in = P1; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (50) @(posedge clk);
    #1;
    chk_int("R1 busy before mid reset", int'(busy_o), 1);
    rst_ni = 1'b0;
    #1;
    chk_int("R1 busy after mid reset", int'(busy_o), 0);
    chk128("R1 state after mid reset", state_o, '0);
    chk128("R1 key after mid reset", key_o, '0);
    @(negedge clk);
    rst_ni = 1'b1;
    begin
      int seen;
      seen = 0;
      for (int c = 0; c < LAT + 20; c++) begin
        @(posedge clk); #1;
        if (done_o) seen++;
      end
      chk_int("R1 no done after aborted operation", seen, 0);
    end

    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule